// File: doc/BRIEF.md
# Sidetone Coefficient and Gain Register Block

This block is the register front end of an audio sidetone path. A host reaches it over a plain 32-bit register bus: a byte address, a write strobe, write data, and read data that responds in the same cycle. It keeps the settings that a downstream filter datapath needs: an auto-idle control, a sidetone enable, and two signed 16-bit channel gains. It also keeps a table of signed 16-bit filter taps. The datapath reads the tap table through a separate index/data port. The filter arithmetic, the interrupt sources and the serial audio port are not part of this block.

The tap table is filled one word at a time through a single data register. Software first raises the load-enable bit in the control register. It then writes the taps in order, index 0 first. After that it polls a done bit and drops load-enable. A small state machine runs the load sequence. It has three states:
- `LD_IDLE`: load-enable is low.
- `LD_FILL`: load-enable is high and taps are arriving.
- `LD_FULL`: every tap has been stored.

Its transitions are:
- `LD_IDLE` to `LD_FILL`: a control write sets load-enable.
- `LD_FILL` to `LD_FULL`: the write of the last tap.
- `LD_FILL` or `LD_FULL` back to `LD_IDLE`: a control write clears load-enable.

Top module: `sdt_ctrl_regs`

## Requirements
- R1: After reset, auto_idle is 1, tone_en is 0, both gains are 0, and the control register (0x2C) reads 0.
- R2: Offset 0x00 always reads the constant REV_ID (default 0x00000102), and writes to it have no effect. The interrupt status offset 0x18 reads 0, and so does every unmapped offset.
- R3: Bit 0 of the system configuration register (0x10) drives auto_idle and reads back. The other bits of that register read 0.
- R4: The gain register (0x24) drives gain_ch0 from bits 15:0 and gain_ch1 from bits 31:16, and it reads back the full word.
- R5: Bit 0 of the control register drives tone_en and reads back in bit 0.
- R6: A control write that takes load-enable (bit 1) from 0 to 1 starts a load at tap index 0. Each later write to the data port (0x28) stores bits 15:0 at the next index.
- R7: Control bit 2 (done) reads 1 from the cycle after the 128th stored tap, and it reads 0 before then. Writing bit 2 has no effect.
- R8: Data port writes made while load-enable is 0, or after all 128 taps are stored, leave the tap table unchanged.
- R9: A control write that clears load-enable also clears done.
- R10: gain_ch0, gain_ch1 and tone_en change only on writes to their own register.
- R11: The interrupt enable register (0x1C) stores and reads back a full 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| coef_rd_idx | input | IDX_W | Tap index requested by the datapath |
| coef_rd_data | output | COEF_W | Tap value at coef_rd_idx |
| gain_ch0 | output | 16 | Channel 0 gain, signed |
| gain_ch1 | output | 16 | Channel 1 gain, signed |
| tone_en | output | 1 | Sidetone enable |
| auto_idle | output | 1 | Auto-idle control |

## Verification
If the load index is wrong, the bench sees it as a shifted or stale tap on coef_rd_data. It shows up as soon as the whole table is read back after a load, or after a load that was stopped early and then restarted. If the load state machine is in the wrong state, the done bit is wrong, and the bench catches this on the control read that directly follows the 127th or the 128th data write. A wrong state also shows as a table that changes when a write should have been ignored. A register decode error shows up on the very next output sample or read-back after a write to a neighbouring offset.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
    localparam logic [7:0] OFS_REV   = 8'h00;
    localparam logic [7:0] OFS_SYS   = 8'h10;
    localparam logic [7:0] OFS_IRQST = 8'h18;
    localparam logic [7:0] OFS_IRQEN = 8'h1C;
    localparam logic [7:0] OFS_GAIN  = 8'h24;
    localparam logic [7:0] OFS_COEF  = 8'h28;
    localparam logic [7:0] OFS_CTRL  = 8'h2C;

    localparam int CTL_TONE = 0;
    localparam int CTL_LDEN = 1;
    localparam int CTL_DONE = 2;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_FULL = 2'd2
    } ld_state_e;
endpackage

// File: rtl/sdt_coef_ram.sv
module sdt_coef_ram #(
    parameter int DEPTH  = 128,
    parameter int WIDTH  = 16,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/sdt_coef_loader.sv
module sdt_coef_loader
    import sdt_pkg::*;
#(
    parameter int N_TAPS = 128,
    parameter int IDX_W  = $clog2(N_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_lden,
    input  logic             data_we,
    output logic             lden_o,
    output logic             done_o,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_TAPS - 1);

    ld_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: if (ctl_we && ctl_lden) state_d = LD_FILL;
            LD_FILL: begin
                if (ctl_we && !ctl_lden) begin
                    state_d = LD_IDLE;
                end else if (data_we && idx_q == LAST_IDX) begin
                    state_d = LD_FULL;
                end
            end
            LD_FULL: if (ctl_we && !ctl_lden) state_d = LD_IDLE;
            default: state_d = LD_IDLE;
        endcase
    end

    always_comb begin
        lden_o = 1'b0;
        done_o = 1'b0;
        mem_we = 1'b0;
        unique case (state_q)
            LD_IDLE: ;
            LD_FILL: begin
                lden_o = 1'b1;
                mem_we = data_we;
            end
            LD_FULL: begin
                lden_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == LD_IDLE) begin
            idx_q <= '0;
        end else if (mem_we) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign mem_idx = idx_q;

    p_start_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lden_o) |-> (idx_q == '0));
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(data_we && idx_q == LAST_IDX));
    p_done_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lden_o) |-> !done_o);
    p_no_store_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_we);
endmodule

// File: rtl/sdt_ctrl_regs.sv
module sdt_ctrl_regs
    import sdt_pkg::*;
#(
    parameter int          N_TAPS = 128,
    parameter int          COEF_W = 16,
    parameter int          ADDR_W = 8,
    parameter logic [31:0] REV_ID = 32'h0000_0102,
    localparam int         IDX_W  = $clog2(N_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [IDX_W-1:0]  coef_rd_idx,
    output logic [COEF_W-1:0] coef_rd_data,
    output logic [15:0]       gain_ch0,
    output logic [15:0]       gain_ch1,
    output logic              tone_en,
    output logic              auto_idle
);
    localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0] A_SYS   = ADDR_W'(OFS_SYS);
    localparam logic [ADDR_W-1:0] A_IRQST = ADDR_W'(OFS_IRQST);
    localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(OFS_IRQEN);
    localparam logic [ADDR_W-1:0] A_GAIN  = ADDR_W'(OFS_GAIN);
    localparam logic [ADDR_W-1:0] A_COEF  = ADDR_W'(OFS_COEF);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

    logic             idle_q, tone_q;
    logic [31:0]      gain_q, irqen_q;
    logic             wr_sys, wr_gain, wr_irqen, wr_ctrl, wr_coef;
    logic             lden, done, mem_we;
    logic [IDX_W-1:0] mem_idx;

    assign wr_sys   = bus_we && bus_addr == A_SYS;
    assign wr_gain  = bus_we && bus_addr == A_GAIN;
    assign wr_irqen = bus_we && bus_addr == A_IRQEN;
    assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
    assign wr_coef  = bus_we && bus_addr == A_COEF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q  <= 1'b1;
            tone_q  <= 1'b0;
            gain_q  <= '0;
            irqen_q <= '0;
        end else begin
            if (wr_sys)   idle_q  <= bus_wdata[0];
            if (wr_ctrl)  tone_q  <= bus_wdata[CTL_TONE];
            if (wr_gain)  gain_q  <= bus_wdata;
            if (wr_irqen) irqen_q <= bus_wdata;
        end
    end

    sdt_coef_loader #(.N_TAPS(N_TAPS), .IDX_W(IDX_W)) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_we  (wr_ctrl),
        .ctl_lden(bus_wdata[CTL_LDEN]),
        .data_we (wr_coef),
        .lden_o  (lden),
        .done_o  (done),
        .mem_we  (mem_we),
        .mem_idx (mem_idx)
    );

    sdt_coef_ram #(.DEPTH(N_TAPS), .WIDTH(COEF_W), .IDX_W(IDX_W)) u_ram (
        .clk    (clk),
        .we     (mem_we),
        .wr_idx (mem_idx),
        .wr_data(bus_wdata[COEF_W-1:0]),
        .rd_idx (coef_rd_idx),
        .rd_data(coef_rd_data)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REV:   bus_rdata = REV_ID;
            A_SYS:   bus_rdata = {31'd0, idle_q};
            A_IRQST: bus_rdata = '0;
            A_IRQEN: bus_rdata = irqen_q;
            A_GAIN:  bus_rdata = gain_q;
            A_CTRL:  bus_rdata = {29'd0, done, lden, tone_q};
            default: bus_rdata = '0;
        endcase
    end

    assign gain_ch0  = gain_q[15:0];
    assign gain_ch1  = gain_q[31:16];
    assign tone_en   = tone_q;
    assign auto_idle = idle_q;

    p_rev_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_REV) |-> (bus_rdata == REV_ID));
    p_gain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gain |=> $stable({gain_ch1, gain_ch0}));
    p_tone_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(tone_en));
    p_done_implies_lden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lden);
endmodule

// File: tb/test_sdt_ctrl_regs.sv
`timescale 1ns/1ps
module test_sdt_ctrl_regs;
    localparam int N = 128;
    localparam logic [31:0] REV = 32'h0000_0102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  coef_rd_idx = '0;
    logic [15:0] coef_rd_data, gain_ch0, gain_ch1;
    logic        tone_en, auto_idle;

    int total = 0;
    int bad = 0;
    logic [15:0] model [N];

    always #4 clk = ~clk;

    sdt_ctrl_regs i_sdt_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .coef_rd_idx(coef_rd_idx),
        .coef_rd_data(coef_rd_data), .gain_ch0(gain_ch0), .gain_ch1(gain_ch1),
        .tone_en(tone_en), .auto_idle(auto_idle)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h3C;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [15:0] tap(input int i, input int s);
        return 16'((i * (2 * s + 1) * 37 + s * 911) & 16'hFFFF);
    endfunction

    task automatic check_table(input string req);
        int errs = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            coef_rd_idx = 7'(i);
            #1;
            if (coef_rd_data !== model[i]) begin
                errs++;
                if (errs < 4) $display("FAIL %s: tap %0d actual=%h expected=%h",
                                       req, i, coef_rd_data, model[i]);
            end
        end
        total++;
        if (errs != 0) bad++;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 auto_idle", {31'd0, auto_idle}, 32'd1);
        check("R1 tone_en", {31'd0, tone_en}, 32'd0);
        check("R1 gains", {gain_ch1, gain_ch0}, 32'd0);
        rd(8'h2C, r); check("R1 ctrl", r, 32'd0);

        // R2 revision, status, unmapped
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); check("R2 rev", r, REV);
        rd(8'h18, r); check("R2 irq status", r, 32'd0);
        for (int a = 0; a < 64; a += 4) begin
            if (a != 0 && a != 8'h10 && a != 8'h1C && a != 8'h24 && a != 8'h2C) begin
                rd(8'(a), r); check("R2 unmapped", r, 32'd0);
            end
        end

        // R3 system config
        wr(8'h10, 32'hFFFF_FFFE);
        check("R3 auto_idle cleared", {31'd0, auto_idle}, 32'd0);
        rd(8'h10, r); check("R3 readback", r, 32'd0);
        wr(8'h10, 32'h0000_0001);
        check("R3 auto_idle set", {31'd0, auto_idle}, 32'd1);

        // R4 gain sweep, R10 tone untouched
        for (int k = 0; k < 6; k++) begin
            logic [31:0] g;
            g = 32'h8001_7FFF ^ (32'(k) * 32'h1357_9BDF);
            wr(8'h24, g);
            check("R4 ch0", {16'd0, gain_ch0}, {16'd0, g[15:0]});
            check("R4 ch1", {16'd0, gain_ch1}, {16'd0, g[31:16]});
            rd(8'h24, r); check("R4 readback", r, g);
            check("R10 tone held", {31'd0, tone_en}, 32'd0);
        end

        // R5 tone enable
        wr(8'h2C, 32'h0000_0001);
        check("R5 tone_en", {31'd0, tone_en}, 32'd1);
        rd(8'h2C, r); check("R5 readback", r, 32'd1);

        // R11 irq enable
        wr(8'h1C, 32'hA5C3_0F96);
        rd(8'h1C, r); check("R11 irq enable", r, 32'hA5C3_0F96);

        // R6/R7 full load, seed 1
        wr(8'h2C, 32'h0000_0003);
        for (int i = 0; i < N; i++) begin
            model[i] = tap(i, 1);
            wr(8'h28, {~model[i], model[i]});
            if (i == N - 2) begin
                rd(8'h2C, r); check("R7 not done at 127", r, 32'd3);
            end
        end
        rd(8'h2C, r); check("R7 done at 128", r, 32'd7);
        check_table("R6 full load");
        check("R10 gain held", {gain_ch1, gain_ch0},
              32'h8001_7FFF ^ (32'd5 * 32'h1357_9BDF));

        // R8 writes after full ignored
        for (int i = 0; i < 4; i++) wr(8'h28, 32'h0000_DEAD);
        check_table("R8 after full");

        // R9 clear enable
        wr(8'h2C, 32'h0000_0001);
        rd(8'h2C, r); check("R9 done cleared", r, 32'd1);
        for (int i = 0; i < 4; i++) wr(8'h28, 32'h0000_BEEF);
        check_table("R8 while disabled");

        // R6 restart from index 0 after partial load; R7 done read-only
        wr(8'h2C, 32'h0000_0003);
        for (int i = 0; i < 5; i++) begin
            model[i] = tap(i, 2);
            wr(8'h28, {16'h1234, model[i]});
        end
        wr(8'h2C, 32'h0000_0007);
        rd(8'h2C, r); check("R7 done read-only", r, 32'd3);
        wr(8'h2C, 32'h0000_0001);
        wr(8'h2C, 32'h0000_0003);
        model[0] = tap(0, 3) ^ 16'h5A5A;
        wr(8'h28, {16'hFFFF, model[0]});
        check_table("R6 restart");
        rd(8'h2C, r); check("R7 partial not done", r, 32'd3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule